// File: doc/BRIEF.md
# Direct-Mapped Multiword Data Cache

This block sits between a word-addressed 32-bit processor and a slower lower memory. It holds a number of lines, each with a block of several consecutive words, one valid flag and a stored tag. The processor places a word address on the request port and holds it there until the cache raises its ready flag. A read that finds its line present completes at once, and the word follows one cycle later. Any other access stalls the processor while the cache works through the memory port.

The line is chosen by the block address modulo the line count. When a read or a write misses, the cache fetches the whole block word by word from lower memory and installs it. It then retries the access, which now hits. Every write, hit or miss, ends with a write-through to lower memory, and the word is merged into the line in the cycle that memory acknowledges it. The memory port issues one word request at a time and holds it until it is acknowledged.

With the default parameters, 1024 lines of four 32-bit words split a 30-bit word address into a 2-bit word offset in bits 1:0, a 10-bit index in bits 11:2 and an 18-bit tag in bits 29:12.

Top module: `direct_mapped_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses: ready stays low in the request cycle and a block fetch starts on the memory port.
- R2: The line is selected by address bits 11:2 and the tag is bits 29:12. A hit needs the line valid and the tags equal. Two addresses that share the index but differ in tag evict each other, so alternating between them misses every time.
- R3: A read hit raises cpuReady in the same cycle the request is presented. In the next cycle cpuRvalid is high for one cycle, and cpuRdata carries the word at the requested address.
- R4: A miss issues exactly four memory reads for the block, with memory addresses {tag, index, offset} and offsets 0, 1, 2, 3 in that order. After the fourth word has been acknowledged, the retried access completes as a hit.
- R5: The data returned after a read miss equals the lower-memory word at the requested address, and the other words of the filled block then hit with their memory values.
- R6: A write that hits issues exactly one memory write (memWe=1) with the processor's address and data, and no memory read. cpuReady rises in the cycle memAck is seen. A later read of that word hits and returns the new data.
- R7: A write that misses first fetches the whole block (four reads), then performs one write-through. Afterwards the written word reads back as the new data and the other block words read back as their memory values, all as hits.
- R8: While memReq is high and memAck has not arrived, memReq, memWe and memAddr stay unchanged.
- R9: A read hit causes no memory traffic.
- R10: cpuRvalid is raised only after an accepted read, never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 30 | Word address |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Request accepted in this cycle |
| cpuRdata | output | 32 | Read data, valid with cpuRvalid |
| cpuRvalid | output | 1 | Read data strobe, one cycle after acceptance of a read |
| memReq | output | 1 | Memory word request, held until memAck |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | 30 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory completion; for reads memRdata is valid in this cycle |
| memRdata | input | 32 | Memory read data |

## Verification
A read hit is due with ready in the request cycle and with data on the next cycle. The bench therefore drives each request just after a falling edge and looks at ready before the following rising edge. It pushes the expected word into a queue at acceptance, and a monitor pops and compares it at the falling edge that follows the accepting rising edge. A miss or a write has no fixed latency, because it depends on the memory model's acknowledge delay. For these, the bench counts the stalled cycles and checks the memory traffic between request and acceptance: the number of reads and writes and the order of the fill addresses. It also checks after each write that no data strobe follows.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WTHRU
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillWe;     // store memRdata at fill offset
    logic setValid;   // mark line valid, record tag
    logic mergeWe;    // store processor write word
    logic rdCapture;  // register read word for return
  } dpStrobe_t;
endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [DATA_W-1:0]         cpuWdata,
  input  logic [DATA_W-1:0]         memRdata,
  input  dpStrobe_t                 strobe,
  input  logic [$clog2(WORDS)-1:0]  fillOff,
  output logic                      hit,
  output logic [DATA_W-1:0]         cpuRdata,
  output logic                      cpuRvalid
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = DATA_W * WORDS;

  logic [OFF_W-1:0] offField;
  logic [IDX_W-1:0] idxField;
  logic [TAG_W-1:0] tagField;

  assign offField = cpuAddr[OFF_W-1:0];
  assign idxField = cpuAddr[OFF_W +: IDX_W];
  assign tagField = cpuAddr[ADDR_W-1 -: TAG_W];

  logic [LINES-1:0] validBits;
  logic [TAG_W-1:0] tagMem  [LINES];
  logic [BLK_W-1:0] dataMem [LINES];

  always_ff @(posedge clk) begin
    if (!rstN) validBits <= '0;
    else if (strobe.setValid) validBits[idxField] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.setValid) tagMem[idxField] <= tagField;
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe)
      dataMem[idxField][fillOff*DATA_W +: DATA_W] <= memRdata;
    else if (strobe.mergeWe)
      dataMem[idxField][offField*DATA_W +: DATA_W] <= cpuWdata;
  end

  assign hit = validBits[idxField] && (tagMem[idxField] == tagField);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRvalid <= 1'b0;
      cpuRdata  <= '0;
    end else begin
      cpuRvalid <= strobe.rdCapture;
      if (strobe.rdCapture)
        cpuRdata <= dataMem[idxField][offField*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuReq,
  input  logic                      cpuWe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic                      hit,
  input  logic                      memAck,
  output logic                      cpuReady,
  output logic                      memReq,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output dpStrobe_t                 strobe,
  output logic [$clog2(WORDS)-1:0]  fillOff
);
  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  cacheState_t state, stateNext;
  logic [OFF_W-1:0] wordCnt;

  assign fillOff = wordCnt;

  always_comb begin
    stateNext = state;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memAddr   = cpuAddr;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (!hit) begin
            stateNext = ST_FILL;
          end else if (cpuWe) begin
            stateNext = ST_WTHRU;
          end else begin
            cpuReady         = 1'b1;
            strobe.rdCapture = 1'b1;
          end
        end
      end
      ST_FILL: begin
        memReq  = 1'b1;
        memAddr = {cpuAddr[ADDR_W-1:OFF_W], wordCnt};
        if (memAck) begin
          strobe.fillWe = 1'b1;
          if (wordCnt == LAST_OFF) begin
            strobe.setValid = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.mergeWe = 1'b1;
          cpuReady       = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) wordCnt <= '0;
      else if (state == ST_FILL && memAck) wordCnt <= wordCnt + 1'b1;
    end
  end
endmodule

// File: rtl/direct_mapped_cache.sv
module direct_mapped_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int OFF_W = $clog2(WORDS);

  dpStrobe_t        strobe;
  logic [OFF_W-1:0] fillOff;
  logic             hit;

  assign memWdata = cpuWdata;

  cache_control #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .hit(hit), .memAck(memAck), .cpuReady(cpuReady), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .strobe(strobe), .fillOff(fillOff)
  );

  cache_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .strobe(strobe), .fillOff(fillOff), .hit(hit),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid)
  );
endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              cpuReady,
  input logic              cpuRvalid,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck
);
  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R8

  AST_FILL_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !memWe |-> memAddr[OFF_W-1:0] == '0); // R4

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck && (memAddr[OFF_W-1:0] != LAST_OFF) |=>
      memReq && !memWe &&
      (memAddr[OFF_W-1:0] - $past(memAddr[OFF_W-1:0]) == OFF_W'(1))); // R4

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && cpuReady |-> !memReq); // R9

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && cpuReady |->
      memReq && memWe && memAck && memAddr == cpuAddr && memWdata == cpuWdata); // R6

  AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRvalid |-> $past(cpuReq && !cpuWe && cpuReady)); // R10
endmodule

bind direct_mapped_cache cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRvalid(cpuRvalid), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/test_direct_mapped_cache.sv
module test_direct_mapped_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [29:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        cpuRvalid;
  logic        memReq;
  logic        memWe;
  logic [29:0] memAddr;
  logic [31:0] memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  direct_mapped_cache i_direct_mapped_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .cpuRvalid(cpuRvalid), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- lower memory model ----------------
  logic [31:0] memStore [logic [29:0]];
  logic [29:0] fillLog [$];
  int rdCount = 0;
  int wrCount = 0;
  int waitCnt = 0;
  logic [29:0] reqAddr = '0;

  function automatic logic [31:0] memVal(input logic [29:0] a);
    if (memStore.exists(a)) return memStore[a];
    return 32'({2'b00, a} * 32'h9E37_79B1) + 32'h1234_5678;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt == 0) reqAddr <= memAddr;
      if (waitCnt == 2) begin
        chk(memAddr == reqAddr, "R8", "memAddr held while pending", memAddr, reqAddr);
        memAck <= 1'b1;
        if (memWe) begin
          memStore[memAddr] = memWdata;
          wrCount++;
        end else begin
          memRdata <= memVal(memAddr);
          rdCount++;
          fillLog.push_back(memAddr);
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expQ [$];
  logic [17:0] tagModel [logic [9:0]];

  always @(negedge clk) begin
    if (rstN && cpuRvalid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "data strobe with no read pending", 1, 0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(cpuRdata == e, "R3/R5", "read data", cpuRdata, e);
      end
    end
  end

  task automatic access(input bit we, input logic [29:0] a, input logic [31:0] d,
                        input string req);
    bit expHit;
    int waits;
    int rd0;
    int wr0;
    expHit = tagModel.exists(a[11:2]) && (tagModel[a[11:2]] == a[29:12]);
    rd0 = rdCount;
    wr0 = wrCount;
    fillLog.delete();
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    #1;
    waits = 0;
    while (!cpuReady && waits < 200) begin
      @(negedge clk);
      waits++;
    end
    if (!we) expQ.push_back(memVal(a));
    @(posedge clk);
    #1;
    cpuReq = 1'b0;
    tagModel[a[11:2]] = a[29:12];
    if (!expHit) begin
      chk(waits > 0, req, "miss must stall", waits, 1);
      chk(rdCount - rd0 == 4, "R4", "fill read count", rdCount - rd0, 4);
      for (int k = 0; k < 4 && k < fillLog.size(); k++)
        chk(fillLog[k] == {a[29:2], 2'(k)}, "R4", "fill address order",
            fillLog[k], {a[29:2], 2'(k)});
    end else begin
      chk(rdCount == rd0, "R9", "no memory read on hit", rdCount - rd0, 0);
      if (!we) chk(waits == 0, "R3", "read hit ready in request cycle", waits, 0);
    end
    chk(wrCount - wr0 == int'(we), we ? (expHit ? "R6" : "R7") : "R9",
        "memory write count", wrCount - wr0, int'(we));
    if (we) begin
      @(negedge clk);
      chk(!cpuRvalid, "R10", "no data strobe after write", cpuRvalid, 0);
    end
  endtask

  localparam logic [29:0] ADDR_A = 30'h0000_0040;
  localparam logic [29:0] ADDR_B = 30'h0000_1040;
  localparam logic [29:0] ADDR_C = 30'h0000_0084;

  initial begin
    repeat (3) @(negedge clk);
    chk(!cpuReady, "R1", "reset cpuReady", cpuReady, 0);
    chk(!cpuRvalid, "R1", "reset cpuRvalid", cpuRvalid, 0);
    chk(!memReq, "R1", "reset memReq", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    access(0, ADDR_A + 30'd1, '0, "R1");           // cold miss
    access(0, ADDR_A + 30'd3, '0, "R5");           // hit, other word of block
    access(0, ADDR_A + 30'd0, '0, "R5");
    access(1, ADDR_A + 30'd2, 32'hCAFE_0002, "R6"); // write hit
    access(0, ADDR_A + 30'd2, '0, "R6");           // new data, hit
    access(0, ADDR_B + 30'd2, '0, "R2");           // conflict miss
    access(0, ADDR_A + 30'd2, '0, "R2");           // evicted again
    access(1, ADDR_C + 30'd1, 32'h5EED_0001, "R7"); // write miss
    access(0, ADDR_C + 30'd1, '0, "R7");
    access(0, ADDR_C + 30'd0, '0, "R7");
    access(0, ADDR_C + 30'd3, '0, "R7");

    for (int i = 0; i < 24; i++) begin
      logic [29:0] a;
      a = 30'(((i % 2) * 32'h2000) + 32'h0200 + ((i * 5) % 16));
      access((i % 3) == 0, a, 32'hA500_0000 + 32'(i), "R2");
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R3", "all reads returned data", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule